// File: doc/BRIEF.md
# SPI Slave with Write-Collision Detection

This block is the slave end of a byte-wide SPI link. A fast system clock oversamples the serial pins: clock, data in and select. The block shifts a byte out on its data output while it shifts a byte in from the master's data line, most significant bit first. Two static inputs choose the clock's idle level and which of the two transfer formats is in use.

On the parallel side, local logic loads the next byte to send with a one-cycle write strobe. It collects each completed incoming byte together with a one-cycle valid pulse.

A write that arrives while a transfer is running is refused. The transmit shift path keeps its contents and a sticky collision flag is raised. The flag stays set until a clear strobe is given. The data output is driven only while the slave is selected. In the sample-first format, each select-low window carries exactly one byte. In the drive-first format, select may stay low across any number of bytes.

Top module: `spi_slave_cd`

## Requirements
- R1: All four combinations of `cpol` and `cpha` carry a full byte in both directions at once. A byte sent by the master appears on `rx_data`, and the byte last accepted through `wr_data` appears on `miso_o`. When `cpol` is 0, SCLK idles low and its leading edge is the rising one. When `cpol` is 1, SCLK idles high and its leading edge is the falling one.
- R2: Both directions are most significant bit first. The first bit on `miso_o` is bit 7 of the loaded byte, and the first bit taken from `mosi` becomes bit 7 of `rx_data`.
- R3: While `nss` is high, `miso_oe` is 0 (the output is high-impedance). It is 0 no later than the third system clock edge after `nss` rises.
- R4: With `cpha` = 0, the bit-7 value is on `miso_o` from the fall of `nss`. `mosi` is sampled on each leading SCLK edge, and `miso_o` advances on each trailing edge.
- R5: With `cpha` = 1, `miso_o` advances on each leading edge and `mosi` is sampled on each trailing edge. The first leading edge of a byte loads the data register. `nss` may stay low across consecutive bytes, and each byte ends at its eighth trailing edge.
- R6: Each completed byte raises `rx_valid` for exactly one system clock. `rx_data` changes only in a cycle in which `rx_valid` is 1.
- R7: With `cpha` = 0, a write while `nss` is low sets `wcol` and is discarded, so the byte sent is unchanged. A write while `nss` is high never sets `wcol`.
- R8: With `cpha` = 1, a write between the first leading edge and the eighth trailing edge of a byte sets `wcol` and is discarded. A write between bytes with `nss` still low is accepted and sent as the next byte.
- R9: `wcol` stays 1 until `wcol_clr` is pulsed. If a collision and `wcol_clr` occur in the same cycle, the flag is set.
- R10: If `nss` rises before the eighth sampling edge, the partial byte is dropped. No `rx_valid` pulse is raised, and the next frame starts again from bit 7.
- R11: After reset, `miso_oe`, `rx_valid`, `wcol` and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the SCLK rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | Clock idle level: 0 idles low, 1 idles high |
| cpha | input | 1 | Format: 0 samples on the leading edge, 1 drives on the leading edge |
| sclk | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| nss | input | 1 | Slave select, active low |
| miso_o | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the data line; 0 means high-impedance |
| wr_en | input | 1 | Write strobe for the transmit data register |
| wr_data | input | DATA_W | Byte to transmit |
| rx_data | output | DATA_W | Last completed received byte |
| rx_valid | output | 1 | One-cycle pulse when a byte completes |
| wcol | output | 1 | Sticky write-collision flag |
| wcol_clr | input | 1 | Clears the collision flag |

## Verification
On every cycle, the assertions check that a valid pulse lasts a single cycle and that the received byte never changes outside such a pulse. They also check that the output enable drops once select has been high for three samples. The collision flag is checked to hold until it is cleared, to drop on a clear that comes with no write, and never to rise from a write made while the slave is deselected. Only the bench's scenarios can show that bytes arrive intact and in bit order in every mode. The same holds for a refused write leaving the transmitted byte unchanged, a write between drive-first bytes taking effect, and an aborted frame producing no byte.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;

    typedef enum logic {
        PH_SAMPLE_FIRST = 1'b0,
        PH_DRIVE_FIRST  = 1'b1
    } phase_e;

    // Leading edge leaves the idle level; trailing edge returns to it.
    function automatic logic edge_lead(input logic pol, input logic rise, input logic fall);
        return pol ? fall : rise;
    endfunction

    function automatic logic edge_trail(input logic pol, input logic rise, input logic fall);
        return pol ? rise : fall;
    endfunction

endpackage

// File: rtl/spi_sync_bus.sv
module spi_sync_bus #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det #(
    parameter logic RST = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb prev_d = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST;
        else        prev_q <= prev_d;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/spi_wcol_flag.sv
module spi_wcol_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr) flag_d = 1'b0;
        if (set) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/spi_slave_cd.sv
module spi_slave_cd
    import spi_slave_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              sclk,
    input  logic              mosi,
    input  logic              nss,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              wcol,
    input  logic              wcol_clr
);
    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic [DATA_W-1:0] dr;
        logic [DATA_W-1:0] rxd;
        logic [CNT_W-1:0]  cnt;
        logic              mid;
        logic              rxv;
    } state_t;

    state_t s_d, s_q;

    logic [2:0] pins_lvl;
    logic sclk_lvl, mosi_lvl, nss_lvl;
    logic sclk_rise, sclk_fall, nss_rise, nss_fall;
    logic lead, trail, sample, drive, sel, busy, wr_take, wcol_set, last_bit;
    logic [DATA_W-1:0] rx_next, tx_shift;
    phase_e phase;

    spi_sync_bus #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({nss, mosi, sclk}), .dout(pins_lvl)
    );

    assign sclk_lvl = pins_lvl[0];
    assign mosi_lvl = pins_lvl[1];
    assign nss_lvl  = pins_lvl[2];

    spi_edge_det #(.RST(1'b0)) u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .lvl(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall)
    );

    spi_edge_det #(.RST(1'b1)) u_nss_edge (
        .clk(clk), .rst_n(rst_n), .lvl(nss_lvl), .rise(nss_rise), .fall(nss_fall)
    );

    spi_wcol_flag u_wcol (
        .clk(clk), .rst_n(rst_n), .set(wcol_set), .clr(wcol_clr), .flag(wcol)
    );

    assign phase = phase_e'(cpha);

    always_comb begin
        s_d      = s_q;
        s_d.rxv  = 1'b0;
        lead     = edge_lead(cpol, sclk_rise, sclk_fall);
        trail    = edge_trail(cpol, sclk_rise, sclk_fall);
        sample   = (phase == PH_SAMPLE_FIRST) ? lead : trail;
        drive    = (phase == PH_SAMPLE_FIRST) ? trail : lead;
        sel      = ~nss_lvl;
        busy     = sel & ((phase == PH_SAMPLE_FIRST) | (s_q.cnt != '0) | s_q.mid);
        wr_take  = wr_en & ~busy;
        wcol_set = wr_en & busy;
        rx_next  = {s_q.rx[DATA_W-2:0], mosi_lvl};
        tx_shift = {s_q.tx[DATA_W-2:0], 1'b0};
        last_bit = (s_q.cnt == LAST);

        if (wr_take) s_d.dr = wr_data;

        if (nss_fall) begin
            s_d.tx  = s_q.dr;
            s_d.cnt = '0;
            s_d.mid = 1'b0;
        end else if (nss_rise) begin
            s_d.cnt = '0;
            s_d.mid = 1'b0;
        end else if (sel) begin
            if (drive) begin
                if (phase == PH_DRIVE_FIRST) begin
                    s_d.mid = 1'b1;
                    s_d.tx  = (s_q.cnt == '0) ? s_q.dr : tx_shift;
                end else begin
                    s_d.tx  = tx_shift;
                end
            end
            if (sample) begin
                s_d.rx  = rx_next;
                s_d.mid = 1'b0;
                if (last_bit) begin
                    s_d.rxd = rx_next;
                    s_d.rxv = 1'b1;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign miso_o   = s_q.tx[DATA_W-1];
    assign miso_oe  = sel;
    assign rx_data  = s_q.rxd;
    assign rx_valid = s_q.rxv;
endmodule

// File: rtl/spi_slave_cd_chk.sv
module spi_slave_cd_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              nss,
    input logic              miso_oe,
    input logic              wr_en,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              wcol,
    input logic              wcol_clr
);
    assert_hiz_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (nss && $past(nss) && $past(nss, 2)) |-> !miso_oe);

    assert_rx_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_rx_data_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> rx_valid);

    assert_idle_write_no_wcol_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wcol && nss && $past(nss) && $past(nss, 2)) |=> !wcol);

    assert_wcol_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wcol && !wcol_clr) |=> wcol);

    assert_wcol_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wcol_clr && !wr_en) |=> !wcol);
endmodule

bind spi_slave_cd spi_slave_cd_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .nss(nss), .miso_oe(miso_oe), .wr_en(wr_en),
    .rx_data(rx_data), .rx_valid(rx_valid), .wcol(wcol), .wcol_clr(wcol_clr)
);

// File: tb/spi_slave_cd_tb.sv
`timescale 1ns/1ps
module spi_slave_cd_tb;
    localparam int HALF = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpol = 1'b0, cpha = 1'b0, sclk = 1'b0, mosi = 1'b0, nss = 1'b1;
    logic wr_en = 1'b0, wcol_clr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic miso_o, miso_oe, rx_valid, wcol;
    logic [7:0] rx_data;

    int n_cmp = 0, n_bad = 0, rxv_cnt = 0, base;
    bit done = 1'b0;
    logic [7:0] last_rx = 8'h00, mi, sb, mb;

    spi_slave_cd u_dut (
        .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .sclk(sclk), .mosi(mosi),
        .nss(nss), .miso_o(miso_o), .miso_oe(miso_oe), .wr_en(wr_en), .wr_data(wr_data),
        .rx_data(rx_data), .rx_valid(rx_valid), .wcol(wcol), .wcol_clr(wcol_clr)
    );

    always #2 clk = ~clk;

    always @(negedge clk) if (rx_valid) begin
        rxv_cnt++;
        last_rx = rx_data;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cpu_write(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic cpu_clear();
        @(negedge clk); wcol_clr = 1'b1;
        @(negedge clk); wcol_clr = 1'b0;
    endtask

    task automatic set_mode(input logic pol, input logic pha);
        @(negedge clk); cpol = pol; cpha = pha; sclk = pol;
        waitn(2 * HALF);
    endtask

    task automatic frame_begin();
        @(negedge clk); nss = 1'b0;
        waitn(HALF);
    endtask

    task automatic frame_end();
        waitn(HALF);
        nss = 1'b1;
        waitn(2 * HALF);
    endtask

    task automatic run_byte(input logic [7:0] mo, input int nbits, input int coll_bit,
                            input logic [7:0] coll_val, output logic [7:0] got);
        got = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            if (cpha == 1'b0) begin
                mosi = mo[i];
                waitn(HALF);
                got[i] = miso_o;
                sclk = ~cpol;
            end else begin
                sclk = ~cpol;
                mosi = mo[i];
            end
            if (coll_bit == 7 - i) begin
                waitn(4); cpu_write(coll_val); waitn(HALF - 6);
            end else begin
                waitn(HALF);
            end
            if (cpha == 1'b1) got[i] = miso_o;
            sclk = cpol;
            if (cpha == 1'b1) waitn(HALF);
        end
        waitn(HALF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog R1 act=hung exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        waitn(5);
        rst_n = 1'b1;
        waitn(2);
        chk("R11 miso_oe", miso_oe, 0);
        chk("R11 rx_valid", rx_valid, 0);
        chk("R11 wcol", wcol, 0);
        chk("R11 rx_data", rx_data, 0);

        // R1/R4/R5/R6 sweep across all modes
        for (int m = 0; m < 4; m++) begin
            set_mode(m[1], m[0]);
            for (int v = 0; v < 32; v++) begin
                sb = 8'(v * 37 + m * 11 + 1);
                mb = 8'(~(v * 53 + m));
                cpu_write(sb);
                base = rxv_cnt;
                frame_begin();
                chk("R3 oe selected", miso_oe, 1);
                run_byte(mb, 8, -1, 8'h00, mi);
                chk(m[0] ? "R5 miso byte" : "R4 miso byte", mi, sb);
                chk("R1 rx byte", last_rx, mb);
                chk("R6 one pulse", rxv_cnt, base + 1);
                frame_end();
                chk("R3 oe deselected", miso_oe, 0);
                chk("R7 no wcol idle write", wcol, 0);
            end
        end

        // R2 bit order
        set_mode(1'b0, 1'b0);
        cpu_write(8'h80);
        frame_begin();
        chk("R2 msb on miso at select", miso_o, 1);
        run_byte(8'h01, 8, -1, 8'h00, mi);
        chk("R2 miso order", mi, 8'h80);
        chk("R2 rx order", last_rx, 8'h01);
        frame_end();

        // R7 / R9 collisions in sample-first format
        set_mode(1'b1, 1'b0);
        cpu_write(8'hA5);
        frame_begin();
        cpu_write(8'h3C);
        chk("R7 wcol set", wcol, 1);
        run_byte(8'h11, 8, 2, 8'h77, mi);
        chk("R7 write discarded", mi, 8'hA5);
        frame_end();
        chk("R9 wcol sticky", wcol, 1);
        cpu_clear();
        chk("R9 wcol cleared", wcol, 0);
        frame_begin();
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h55; wcol_clr = 1'b1;
        @(negedge clk); wr_en = 1'b0; wcol_clr = 1'b0;
        chk("R9 set wins", wcol, 1);
        run_byte(8'h22, 8, -1, 8'h00, mi);
        chk("R7 register kept", mi, 8'hA5);
        frame_end();
        cpu_clear();

        // R5 / R8 drive-first format with select held low
        set_mode(1'b0, 1'b1);
        cpu_write(8'h5A);
        base = rxv_cnt;
        frame_begin();
        run_byte(8'hC3, 8, -1, 8'h00, mi);
        chk("R5 first byte", mi, 8'h5A);
        chk("R5 first rx", last_rx, 8'hC3);
        cpu_write(8'h96);
        chk("R8 gap write ok", wcol, 0);
        run_byte(8'h3E, 8, 3, 8'hFF, mi);
        chk("R8 gap write sent", mi, 8'h96);
        chk("R8 mid-byte wcol", wcol, 1);
        chk("R5 second rx", last_rx, 8'h3E);
        run_byte(8'h0F, 8, -1, 8'h00, mi);
        chk("R8 mid write discarded", mi, 8'h96);
        chk("R5 three bytes", rxv_cnt, base + 3);
        frame_end();
        cpu_clear();
        chk("R9 cleared again", wcol, 0);

        // R10 abort mid-byte
        set_mode(1'b0, 1'b0);
        cpu_write(8'hE7);
        base = rxv_cnt;
        frame_begin();
        run_byte(8'hFF, 4, -1, 8'h00, mi);
        frame_end();
        chk("R10 no pulse on abort", rxv_cnt, base);
        frame_begin();
        run_byte(8'h42, 8, -1, 8'h00, mi);
        chk("R10 restart miso", mi, 8'hE7);
        chk("R10 restart rx", last_rx, 8'h42);
        chk("R10 single pulse", rxv_cnt, base + 1);
        frame_end();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule